// File: doc/BRIEF.md
# DDR Write Data Capture

This block takes in write data from a 64-bit double-data-rate bus. The bus is organised as eight byte lanes. Each lane has its own strobe and its own mask bit. Data and mask are latched on every rising and every falling strobe edge. Each rising-edge beat is then paired with the falling-edge beat that follows it. The pair goes to the memory-side write port as one 128-bit word, with a 16-bit byte-enable and a single-cycle valid pulse, all in the core clock domain.

A one-cycle write-start pulse arms the lanes and latches the programmed burst length. A burst of length 2, 4 or 8 yields 1, 2 or 4 valid words. Strobe pairs that arrive while no burst is armed are dropped, as are pairs beyond the programmed length. The strobe edges sit in the centre of the data eye, and strobe-to-clock skew is taken as zero.

Top module: `wcap_ddr_write_capture`

## Requirements
- R1: After reset, and until the first armed strobe pair arrives, `beat_valid` is 0 and `beat_word` and `beat_be` are all zeros.
- R2: Data on lane i at a rising strobe edge appears in `beat_word[8i+7:8i]`. Data on lane i at the following falling edge appears in `beat_word[64+8i+7:64+8i]`.
- R3: `beat_be[i]` is the inverse of lane i's mask bit sampled at the rising edge. `beat_be[8+i]` is the inverse of the mask bit sampled at the falling edge. A mask bit of 1 clears the enable, and the data byte is still presented.
- R4: A `burst_len` value of 2, 4 or 8 at the write-start pulse produces exactly 1, 2 or 4 valid words, one per strobe pair.
- R5: Any other `burst_len` value is treated as 8, so the burst produces 4 valid words.
- R6: Strobe pairs arriving while no burst is armed produce no valid word. This includes pairs beyond the burst length.
- R7: A write-start pulse during an armed burst restarts the beat count from zero, using the newly presented burst length.
- R8: A pair whose rising edge coincides with core clock edge N is delivered with `beat_valid` high in the cycle after edge N+1. Back-to-back pairs give valid on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset; synchronous for core logic, asynchronous for the strobe-side toggles |
| wr_start | input | 1 | One-cycle pulse that arms a write burst |
| burst_len | input | 4 | Programmed burst length, sampled with `wr_start` |
| dqs | input | 8 | Per-lane write data strobes |
| dm | input | 8 | Per-lane write mask, high suppresses the byte |
| dq | input | 64 | Write data bus |
| beat_word | output | 128 | Falling beat in upper half, rising beat in lower half |
| beat_be | output | 16 | Byte-enables: falling beat in upper byte, rising beat in lower byte |
| beat_valid | output | 1 | One-cycle pulse per delivered word |

## Verification
The write-start pulse is sampled at core edge E. The first rising strobe edge then coincides with edge E+1. Pair k is therefore due as a valid word just after edge E+2+k. Each scenario task drives one pair per core cycle and samples the outputs on the following falling clock edge. At that sample point the expected pair is the one driven in the previous cycle. The task compares valid, word and enables every cycle, including the cycles where no word is due. After the last pair it also compares the total number of valid pulses against the burst length.

// File: rtl/wcap_pkg.sv
package wcap_pkg;
   localparam int unsigned PAIR_CNT_W = 3;
   localparam int unsigned MAX_PAIRS  = 4;

   // Number of rising/falling pairs for a programmed burst length.
   function automatic logic [PAIR_CNT_W-1:0] pairs_for_len(input int unsigned len);
      logic [PAIR_CNT_W-1:0] n;
      case (len)
         2:       n = PAIR_CNT_W'(1);
         4:       n = PAIR_CNT_W'(2);
         8:       n = PAIR_CNT_W'(4);
         default: n = PAIR_CNT_W'(MAX_PAIRS);
      endcase
      return n;
   endfunction
endpackage

// File: rtl/wcap_strobe_capture.sv
module wcap_strobe_capture #(
   parameter int unsigned LANE_W = 8
) (
   input  logic              rst_n,
   input  logic              dqs,
   input  logic [LANE_W-1:0] dq,
   input  logic              dm,
   output logic [LANE_W-1:0] rise_dq,
   output logic              rise_dm,
   output logic [LANE_W-1:0] fall_dq,
   output logic              fall_dm,
   output logic              pair_tog
);
   // Rising-edge beat holding register.
   always_ff @(posedge dqs) begin
      rise_dq <= dq;
      rise_dm <= dm;
   end

   // Falling-edge beat completes a pair; flip the toggle to announce it.
   always_ff @(negedge dqs) begin
      fall_dq <= dq;
      fall_dm <= dm;
   end

   always_ff @(negedge dqs or negedge rst_n) begin
      if (!rst_n) pair_tog <= 1'b0;
      else        pair_tog <= ~pair_tog;
   end
endmodule

// File: rtl/wcap_lane_track.sv
module wcap_lane_track
   import wcap_pkg::*;
#(
   parameter int unsigned LANE_W           = 8,
   parameter bit          MASK_ACTIVE_HIGH = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [PAIR_CNT_W-1:0] pairs_in,
   input  logic                  pair_tog,
   input  logic [LANE_W-1:0]     rise_dq,
   input  logic                  rise_dm,
   input  logic [LANE_W-1:0]     fall_dq,
   input  logic                  fall_dm,
   output logic                  fire,
   output logic                  busy,
   output logic [2*LANE_W-1:0]   lane_data,
   output logic [1:0]            lane_be
);
   logic                  tog_seen;
   logic                  armed;
   logic [PAIR_CNT_W-1:0] count;
   logic [PAIR_CNT_W-1:0] pairs_q;
   logic                  new_pair;
   logic                  last_pair;

   assign new_pair  = pair_tog ^ tog_seen;
   assign last_pair = (count == PAIR_CNT_W'(pairs_q - PAIR_CNT_W'(1)));
   // A start in the same cycle discards a straggling pair of the old burst.
   assign fire      = new_pair & armed & ~start;
   assign busy      = armed;
   assign lane_data = {fall_dq, rise_dq};

   generate
      if (MASK_ACTIVE_HIGH) begin : g_mask_hi
         assign lane_be = {~fall_dm, ~rise_dm};
      end else begin : g_mask_lo
         assign lane_be = {fall_dm, rise_dm};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tog_seen <= 1'b0;
         armed    <= 1'b0;
         count    <= '0;
         pairs_q  <= '0;
      end else begin
         tog_seen <= pair_tog;
         if (start) begin
            armed   <= 1'b1;
            count   <= '0;
            pairs_q <= pairs_in;
         end else if (fire) begin
            if (last_pair) begin
               armed <= 1'b0;
               count <= '0;
            end else begin
               count <= count + PAIR_CNT_W'(1);
            end
         end
      end
   end

   AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (armed && count == '0)); // R7
   AST_BURST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && last_pair) |=> !armed); // R4
   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (count < pairs_q)); // R4
endmodule

// File: rtl/wcap_ddr_write_capture.sv
module wcap_ddr_write_capture
   import wcap_pkg::*;
#(
   parameter int unsigned NUM_LANES        = 8,
   parameter int unsigned LANE_W           = 8,
   parameter int unsigned BL_W             = 4,
   parameter bit          MASK_ACTIVE_HIGH = 1'b1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_start,
   input  logic [BL_W-1:0]                   burst_len,
   input  logic [NUM_LANES-1:0]              dqs,
   input  logic [NUM_LANES-1:0]              dm,
   input  logic [NUM_LANES*LANE_W-1:0]       dq,
   output logic [2*NUM_LANES*LANE_W-1:0]     beat_word,
   output logic [2*NUM_LANES-1:0]            beat_be,
   output logic                              beat_valid
);
   localparam int unsigned DATA_W = NUM_LANES * LANE_W;

   generate
      if (NUM_LANES < 1) begin : g_bad_lanes
         $error("NUM_LANES must be at least 1");
      end
      if (LANE_W < 1) begin : g_bad_width
         $error("LANE_W must be at least 1");
      end
      if (BL_W < 4) begin : g_bad_bl
         $error("BL_W must hold the value 8");
      end
   endgenerate

   logic [PAIR_CNT_W-1:0]       pairs_sel;
   logic [NUM_LANES-1:0]        fire;
   logic [NUM_LANES-1:0]        busy;
   logic [2*NUM_LANES*LANE_W-1:0] word_d;
   logic [2*NUM_LANES-1:0]      be_d;

   assign pairs_sel = pairs_for_len(32'(burst_len));

   generate
      for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
         logic [LANE_W-1:0]   r_dq, f_dq;
         logic                r_dm, f_dm, tog;
         logic [2*LANE_W-1:0] ldata;
         logic [1:0]          lbe;

         wcap_strobe_capture #(.LANE_W(LANE_W)) u_cap (
            .rst_n   (rst_n),
            .dqs     (dqs[i]),
            .dq      (dq[i*LANE_W +: LANE_W]),
            .dm      (dm[i]),
            .rise_dq (r_dq),
            .rise_dm (r_dm),
            .fall_dq (f_dq),
            .fall_dm (f_dm),
            .pair_tog(tog)
         );

         wcap_lane_track #(.LANE_W(LANE_W), .MASK_ACTIVE_HIGH(MASK_ACTIVE_HIGH)) u_trk (
            .clk      (clk),
            .rst_n    (rst_n),
            .start    (wr_start),
            .pairs_in (pairs_sel),
            .pair_tog (tog),
            .rise_dq  (r_dq),
            .rise_dm  (r_dm),
            .fall_dq  (f_dq),
            .fall_dm  (f_dm),
            .fire     (fire[i]),
            .busy     (busy[i]),
            .lane_data(ldata),
            .lane_be  (lbe)
         );

         assign word_d[i*LANE_W +: LANE_W]          = ldata[LANE_W-1:0];
         assign word_d[DATA_W + i*LANE_W +: LANE_W] = ldata[2*LANE_W-1:LANE_W];
         assign be_d[i]             = lbe[0];
         assign be_d[NUM_LANES + i] = lbe[1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         beat_valid <= 1'b0;
         beat_word  <= '0;
         beat_be    <= '0;
      end else begin
         beat_valid <= &fire;
         if (&fire) begin
            beat_word <= word_d;
            beat_be   <= be_d;
         end
      end
   end

   AST_LANES_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
      (|fire) |-> (&fire)); // R2
   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> !beat_valid); // R1
   AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (busy == '0) |=> !beat_valid); // R6
endmodule

// File: tb/wcap_ddr_write_capture_tb.sv
`timescale 1ns/1ps
module wcap_ddr_write_capture_tb_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_start = 1'b0;
   logic [3:0]   burst_len = 4'd0;
   logic [7:0]   dqs = '0;
   logic [7:0]   dm = '0;
   logic [63:0]  dq = '0;
   logic [127:0] beat_word;
   logic [15:0]  beat_be;
   logic         beat_valid;

   int n_checks = 0;
   int n_bad    = 0;

   always #2 clk = ~clk;

   wcap_ddr_write_capture dut_i (
      .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .burst_len(burst_len),
      .dqs(dqs), .dm(dm), .dq(dq),
      .beat_word(beat_word), .beat_be(beat_be), .beat_valid(beat_valid)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
      n_checks++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] beat_pat(input int p, input logic [63:0] seed);
      return seed ^ {8{8'(p * 37 + 5)}} ^ (64'(p) << 17);
   endfunction

   function automatic logic [7:0] rotl(input logic [7:0] m, input int p);
      int s = p % 8;
      return 8'((m << s) | (m >> (8 - s)));
   endfunction

   // Drives one optional start, then `send` strobe pairs, checking every cycle.
   task automatic run_burst(input string req, input bit do_start, input int code,
                            input int exp_pairs, input int send,
                            input logic [63:0] seed, input logic [7:0] mr,
                            input logic [7:0] mf);
      logic [63:0] cur_r, cur_f, prev_r, prev_f;
      logic [7:0]  cur_mr, cur_mf, prev_mr, prev_mf;
      int nvalid = 0;
      bit exp_v;
      prev_r = '0; prev_f = '0; prev_mr = '0; prev_mf = '0;
      if (do_start) begin
         @(negedge clk);
         wr_start  = 1'b1;
         burst_len = 4'(code);
         @(posedge clk);
         #1 wr_start = 1'b0;
      end
      @(negedge clk);
      #1;
      for (int p = 0; p <= send; p++) begin
         cur_r  = beat_pat(p, seed);
         cur_mr = rotl(mr, p);
         dq = cur_r; dm = cur_mr;
         @(posedge clk);
         if (p < send) dqs = '1;
         #1;
         cur_f  = beat_pat(p, ~seed);
         cur_mf = rotl(mf, p);
         dq = cur_f; dm = cur_mf;
         @(negedge clk);
         // R8: pair p-1 is due just after the edge that ended this cycle's rise
         exp_v = (p >= 1) && (p - 1 < exp_pairs);
         check(beat_valid == exp_v, req, "R8 valid timing", 128'(beat_valid), 128'(exp_v));
         if (beat_valid) nvalid++;
         if (exp_v) begin
            check(beat_word == {prev_f, prev_r}, req, "R2 word", beat_word, {prev_f, prev_r});
            check(beat_be == {~prev_mf, ~prev_mr}, req, "R3 byte enables",
                  128'(beat_be), 128'({~prev_mf, ~prev_mr}));
         end
         if (p < send) dqs = '0;
         prev_r = cur_r; prev_f = cur_f; prev_mr = cur_mr; prev_mf = cur_mf;
         #1;
      end
      check(nvalid == exp_pairs, req, "valid count", 128'(nvalid), 128'(exp_pairs));
   endtask

   task automatic t_reset;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(beat_valid == 1'b0, "R1", "valid in reset", 128'(beat_valid), 128'(0));
      rst_n = 1'b1;
      @(negedge clk);
      check(beat_valid == 1'b0, "R1", "valid after reset", 128'(beat_valid), 128'(0));
      check(beat_word == '0, "R1", "word after reset", beat_word, 128'(0));
      check(beat_be == '0, "R1", "be after reset", 128'(beat_be), 128'(0));
   endtask

   task automatic t_idle;        // R6: pairs with no burst armed
      run_burst("R6", 1'b0, 0, 0, 3, 64'hA5A5_0F0F_3C3C_9696, 8'h00, 8'h00);
   endtask

   task automatic t_bl2;         // R4
      run_burst("R4", 1'b1, 2, 1, 1, 64'h0123_4567_89AB_CDEF, 8'h00, 8'h00);
   endtask

   task automatic t_bl4_extra;   // R4 + R6: extra pairs beyond length dropped
      run_burst("R4", 1'b1, 4, 2, 4, 64'hFEDC_BA98_7654_3210, 8'h01, 8'h80);
   endtask

   task automatic t_bl8_masks;   // R3 + R8: masks on both edges, back-to-back
      run_burst("R3", 1'b1, 8, 4, 4, 64'h55AA_33CC_0FF0_1234, 8'h25, 8'hC3);
   endtask

   task automatic t_bl_other;    // R5: unsupported length acts as 8
      run_burst("R5", 1'b1, 5, 4, 5, 64'hDEAD_BEEF_CAFE_F00D, 8'hFF, 8'h00);
      run_burst("R5", 1'b1, 0, 4, 4, 64'h1111_2222_3333_4444, 8'h10, 8'h01);
   endtask

   task automatic t_restart;     // R7: restart mid-burst
      run_burst("R7", 1'b1, 8, 2, 2, 64'h7777_8888_9999_AAAA, 8'h00, 8'h00);
      run_burst("R7", 1'b1, 2, 1, 3, 64'h0BAD_F00D_1357_2468, 8'h02, 8'h04);
   endtask

   task automatic finish_report;
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   endtask

   initial begin
      #(200000 * 4);
      n_checks++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_report();
   end

   initial begin
      t_reset();
      t_idle();
      t_bl2();
      t_bl4_extra();
      t_bl8_masks();
      t_bl_other();
      t_restart();
      t_idle();
      repeat (2) @(posedge clk);
      finish_report();
   end
endmodule